// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller services one cache line refill at a time after a miss. When the miss arrives with the index of the word the processor wants, the controller issues one word request per accepted handshake to the next level of memory. It writes each returning word into an external line buffer at the right slot, and hands the wanted word to the processor in the very cycle it comes back. The processor is released by that hand-off and does not wait for the rest of the line.

A static mode input picks the fetch order. With wrapping order the wanted word is requested first and the remaining words follow upward, wrapping past the end of the line. With sequential order the words are requested from slot 0 upward, and the wanted word is still handed over on the cycle it arrives. Word responses return in request order. The line is marked complete only after every word is written. While the refill runs, reads to the line stall unless the word has already landed in the buffer.

Top module: `refill_ctrl`

## Requirements
- R1: The line is LINE_BYTES = 64 bytes of WORD_W = 32-bit words, so a refill moves 16 words with 4-bit slot indices; slot i holds line bytes 4i to 4i+3.
- R2: Out of reset `busy`, `line_valid`, `mem_req_valid`, `buf_we` and `fwd_valid` are low. A miss (`miss_valid` high while `busy` is low) is accepted at the clock edge; from the next cycle `busy` is high and `line_valid` is low.
- R3: With `wrap_mode` = 1 the requested slots are crit, crit+1, ... modulo 16, where crit is `miss_idx` at acceptance; the first request is presented in the first busy cycle.
- R4: With `wrap_mode` = 0 the requested slots are 0, 1, ..., 15 in that order, starting in the first busy cycle.
- R5: Each response (`mem_rsp_valid` while busy) is written in that same cycle: `buf_we` high, `buf_widx` equal to the slot of the oldest unanswered request, `buf_wdata` equal to `mem_rsp_data`.
- R6: `fwd_valid` is high for exactly one cycle per miss, the cycle in which the crit slot is written, with `fwd_data` equal to that word.
- R7: In the cycle after the sixteenth write, `busy` is low and `line_valid` is high; it stays high until the next miss is accepted.
- R8: A miss presented while `busy` is high is ignored: the slot order and crit of the refill in progress are unchanged.
- R9: `rd_stall` equals `rd_valid` and not `line_valid` and not (slot `rd_idx` written in an earlier cycle of the current refill).
- R10: `mem_req_valid` is low whenever `busy` is low; a presented request holds its slot until `mem_req_ready`; exactly 16 requests are handshaken per miss.
- R11: A response presented while `busy` is low produces no buffer write and no forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrap_mode | input | 1 | 1: wanted word first then wrap, 0: slot 0 upward |
| miss_valid | input | 1 | Miss request |
| miss_idx | input | 4 | Slot of the wanted word |
| busy | output | 1 | Refill in progress |
| line_valid | output | 1 | Whole line present in the buffer |
| mem_req_valid | output | 1 | Word request to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_idx | output | 4 | Slot requested |
| mem_rsp_valid | input | 1 | Word returned, in request order |
| mem_rsp_data | input | 32 | Returned word |
| buf_we | output | 1 | Line buffer write enable |
| buf_widx | output | 4 | Line buffer write slot |
| buf_wdata | output | 32 | Line buffer write data |
| fwd_valid | output | 1 | Wanted word to the processor |
| fwd_data | output | 32 | Forwarded word |
| rd_valid | input | 1 | Processor read to the refilling line |
| rd_idx | input | 4 | Slot of that read |
| rd_stall | output | 1 | Read must wait |

## Verification
Every one of the 16 wanted-word slots is tried in both orders, so wrapping is exercised from each starting point, including slot 0 where both orders coincide and slot 15 where the wrap happens after one word. Memory readiness drops every third cycle and responses lag requests by two cycles, which separates the request slot from the write slot and shows whether the request holds while not taken. A read probe walks the slots during each refill and tells a word written one cycle earlier apart from one being written now; a stray miss in mid-refill and a response while idle show that neither disturbs the state.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;

  // Slot of the n-th beat of a refill. Wrapping order starts at the wanted
  // slot; sequential order starts at slot 0. mask = slots per line - 1.
  function automatic logic [7:0] line_slot(input logic [7:0] crit,
                                           input logic [7:0] step,
                                           input logic       wrap,
                                           input logic [7:0] mask);
    logic [7:0] raw;
    raw = wrap ? (crit + step) : step;
    return raw & mask;
  endfunction

endpackage

// File: rtl/refill_issue.sv
module refill_issue #(
  parameter int WORDS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             wrap,
  input  logic [IDX_W-1:0] crit,
  input  logic             mem_req_ready,
  output logic             mem_req_valid,
  output logic [IDX_W-1:0] mem_req_idx
);
  import refill_pkg::*;

  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] BEATS = CNT_W'(WORDS);
  localparam logic [7:0] SLOT_MASK = 8'(WORDS - 1);

  logic [CNT_W-1:0] sent;

  assign mem_req_valid = active && (sent < BEATS);
  assign mem_req_idx   = IDX_W'(line_slot(8'(crit), 8'(sent), wrap, SLOT_MASK));

  always_ff @(posedge clk) begin
    if (!rst_n)                              sent <= '0;
    else if (start)                          sent <= '0;
    else if (mem_req_valid && mem_req_ready) sent <= sent + 1'b1;
  end

endmodule

// File: rtl/refill_collect.sv
module refill_collect #(
  parameter int WORDS  = 16,
  parameter int IDX_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              wrap,
  input  logic [IDX_W-1:0]  crit,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_widx,
  output logic [WORD_W-1:0] buf_wdata,
  output logic              fwd_valid,
  output logic [WORD_W-1:0] fwd_data,
  output logic              last_beat,
  output logic              probe_present
);
  import refill_pkg::*;

  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] FINAL = CNT_W'(WORDS - 1);
  localparam logic [7:0] SLOT_MASK = 8'(WORDS - 1);

  logic [CNT_W-1:0] got;
  logic [WORDS-1:0] fill_mask;

  assign buf_we        = active && rsp_valid;
  assign buf_widx      = IDX_W'(line_slot(8'(crit), 8'(got), wrap, SLOT_MASK));
  assign buf_wdata     = rsp_data;
  assign fwd_valid     = buf_we && (buf_widx == crit);
  assign fwd_data      = rsp_data;
  assign last_beat     = buf_we && (got == FINAL);
  assign probe_present = fill_mask[probe_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)      got <= '0;
    else if (start)  got <= '0;
    else if (buf_we) got <= got + 1'b1;
  end

  for (genvar s = 0; s < WORDS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                               fill_mask[s] <= 1'b0;
      else if (start)                           fill_mask[s] <= 1'b0;
      else if (buf_we && buf_widx == IDX_W'(s)) fill_mask[s] <= 1'b1;
    end
  end

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl #(
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 32,
  localparam int WORDS     = LINE_BYTES * 8 / WORD_W,
  localparam int IDX_W     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_mode,
  input  logic              miss_valid,
  input  logic [IDX_W-1:0]  miss_idx,
  output logic              busy,
  output logic              line_valid,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [IDX_W-1:0]  mem_req_idx,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_widx,
  output logic [WORD_W-1:0] buf_wdata,
  output logic              fwd_valid,
  output logic [WORD_W-1:0] fwd_data,
  input  logic              rd_valid,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_stall
);
  import refill_pkg::*;

  fill_state_e      state;
  logic [IDX_W-1:0] crit_q;
  logic             wrap_q;
  logic             line_valid_q;
  logic             accept;
  logic             last_beat;
  logic             word_present;

  assign accept     = miss_valid && (state == ST_IDLE);
  assign busy       = (state == ST_FILL);
  assign line_valid = line_valid_q;
  assign rd_stall   = rd_valid && !line_valid_q && !word_present;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      crit_q       <= '0;
      wrap_q       <= 1'b0;
      line_valid_q <= 1'b0;
    end else if (accept) begin
      state        <= ST_FILL;
      crit_q       <= miss_idx;
      wrap_q       <= wrap_mode;
      line_valid_q <= 1'b0;
    end else if (last_beat) begin
      state        <= ST_IDLE;
      line_valid_q <= 1'b1;
    end
  end

  refill_issue #(.WORDS(WORDS), .IDX_W(IDX_W)) u_issue (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .active        (busy),
    .wrap          (wrap_q),
    .crit          (crit_q),
    .mem_req_ready (mem_req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_idx   (mem_req_idx)
  );

  refill_collect #(.WORDS(WORDS), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_collect (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .active        (busy),
    .wrap          (wrap_q),
    .crit          (crit_q),
    .rsp_valid     (mem_rsp_valid),
    .rsp_data      (mem_rsp_data),
    .probe_idx     (rd_idx),
    .buf_we        (buf_we),
    .buf_widx      (buf_widx),
    .buf_wdata     (buf_wdata),
    .fwd_valid     (fwd_valid),
    .fwd_data      (fwd_data),
    .last_beat     (last_beat),
    .probe_present (word_present)
  );

endmodule

// File: rtl/refill_ctrl_chk.sv
module refill_ctrl_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             line_valid,
  input logic             miss_valid,
  input logic [IDX_W-1:0] crit_q,
  input logic             wrap_q,
  input logic             mem_req_valid,
  input logic [IDX_W-1:0] mem_req_idx,
  input logic             buf_we,
  input logic             fwd_valid,
  input logic             rd_valid,
  input logic             rd_stall
);
  logic fwd_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                     fwd_seen <= 1'b0;
    else if (miss_valid && !busy)   fwd_seen <= 1'b0;
    else if (fwd_valid)             fwd_seen <= 1'b1;
  end

  a_r3_wrap_starts_at_crit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && wrap_q |-> mem_req_valid && (mem_req_idx == crit_q));

  a_r4_seq_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !wrap_q |-> mem_req_valid && (mem_req_idx == '0));

  a_r6_single_forward: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !fwd_seen && busy);

  a_r7_valid_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_valid) |-> $fell(busy));

  a_r8_miss_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && miss_valid |=> $stable(crit_q) && $stable(wrap_q));

  a_r9_no_stall_when_whole: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && line_valid |-> !rd_stall);

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !buf_we);

endmodule

bind refill_ctrl refill_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .line_valid    (line_valid),
  .miss_valid    (miss_valid),
  .crit_q        (crit_q),
  .wrap_q        (wrap_q),
  .mem_req_valid (mem_req_valid),
  .mem_req_idx   (mem_req_idx),
  .buf_we        (buf_we),
  .fwd_valid     (fwd_valid),
  .rd_valid      (rd_valid),
  .rd_stall      (rd_stall)
);

// File: tb/refill_ctrl_test.sv
module refill_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrap_mode = 1'b0;
  logic        miss_valid = 1'b0;
  logic [3:0]  miss_idx = '0;
  logic        busy, line_valid, mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [3:0]  mem_req_idx;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        buf_we;
  logic [3:0]  buf_widx;
  logic [31:0] buf_wdata;
  logic        fwd_valid;
  logic [31:0] fwd_data;
  logic        rd_valid = 1'b0;
  logic [3:0]  rd_idx = '0;
  logic        rd_stall;

  refill_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wrap_mode(wrap_mode),
    .miss_valid(miss_valid), .miss_idx(miss_idx),
    .busy(busy), .line_valid(line_valid),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_idx(mem_req_idx),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_stall(rd_stall)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int req_n, wr_n, fwd_cnt, head, tail, cur_crit, cur_tag;
  bit cur_mode, lv_m;
  int q[16];
  int due[16];
  bit filled_m[16];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_slot(input bit m, input int c, input int n);
    return m ? (c + n) % 16 : n;
  endfunction

  function automatic logic [31:0] pat(input int idx, input int tag);
    return (32'(tag) << 16) | 32'h0000_5A00 | 32'(idx);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  // One clock of the memory model, read probe and output checks.
  task automatic step();
    bit exp_stall, exp_fwd;
    int s;
    @(negedge clk);
    cyc++;
    mem_req_ready = (cyc % 3 != 0);
    miss_valid = (req_n == 5);          // stray miss during refill (R8)
    miss_idx = 4'(cur_crit ^ 9);
    rd_valid = 1'b1;
    rd_idx = 4'(cyc % 16);
    if (head < tail && cyc >= due[head]) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data = pat(q[head], cur_tag);
      head++;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    #1;
    if (wr_n < 16) chk(busy == 1'b1, "R2", "busy during refill", busy, 1);
    exp_stall = !lv_m && !filled_m[rd_idx];
    chk(rd_stall == exp_stall, "R9", "read stall", rd_stall, exp_stall);
    if (mem_req_valid && mem_req_ready) begin
      chk(req_n < 16, "R10", "request count", req_n, 15);
      if (cur_mode) chk(int'(mem_req_idx) == exp_slot(1, cur_crit, req_n), "R3",
                        "wrapped request slot", mem_req_idx, exp_slot(1, cur_crit, req_n));
      else chk(int'(mem_req_idx) == exp_slot(0, cur_crit, req_n), "R4",
               "sequential request slot", mem_req_idx, exp_slot(0, cur_crit, req_n));
      if (tail < 16) begin
        q[tail] = int'(mem_req_idx);
        due[tail] = cyc + 2;
        tail++;
      end
      req_n++;
    end
    if (mem_rsp_valid) begin
      s = exp_slot(cur_mode, cur_crit, wr_n);
      chk(buf_we == 1'b1, "R5", "write enable", buf_we, 1);
      chk(int'(buf_widx) == s, "R5", "write slot", buf_widx, s);
      chk(buf_wdata == pat(s, cur_tag), "R5", "write data", buf_wdata, pat(s, cur_tag));
      exp_fwd = (s == cur_crit);
      chk(fwd_valid == exp_fwd, "R6", "forward timing", fwd_valid, exp_fwd);
      if (fwd_valid) begin
        fwd_cnt++;
        chk(fwd_data == pat(cur_crit, cur_tag), "R6", "forward data",
            fwd_data, pat(cur_crit, cur_tag));
      end
      filled_m[s] = 1'b1;
      wr_n++;
    end else begin
      chk(buf_we == 1'b0 && fwd_valid == 1'b0, "R5", "no write without response",
          {buf_we, fwd_valid}, 0);
    end
  endtask

  task automatic do_miss(input bit mode, input int crit, input int tag);
    int guard;
    @(negedge clk);
    cyc++;
    mem_rsp_valid = 1'b0;
    mem_req_ready = 1'b0;
    rd_valid = 1'b0;
    wrap_mode = mode;
    miss_valid = 1'b1;
    miss_idx = 4'(crit);
    cur_mode = mode; cur_crit = crit; cur_tag = tag;
    req_n = 0; wr_n = 0; fwd_cnt = 0; head = 0; tail = 0; lv_m = 1'b0;
    for (int i = 0; i < 16; i++) filled_m[i] = 1'b0;
    #1;
    step();
    chk(line_valid == 1'b0, "R2", "line_valid cleared on accept", line_valid, 0);
    guard = 0;
    while (wr_n < 16 && guard < 200) begin
      step();
      guard++;
    end
    @(negedge clk);
    cyc++;
    miss_valid = 1'b0;
    mem_rsp_valid = 1'b0;
    rd_valid = 1'b0;
    #1;
    chk(busy == 1'b0 && line_valid == 1'b1, "R7", "release after last word",
        {busy, line_valid}, 1);
    chk(wr_n == 16, "R1", "16 words per 64-byte line", wr_n, 16);
    chk(req_n == 16, "R10", "requests per miss", req_n, 16);
    chk(fwd_cnt == 1, "R6", "forwards per miss", fwd_cnt, 1);
    chk(mem_req_valid == 1'b0, "R10", "no request when idle", mem_req_valid, 0);
    lv_m = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0 && line_valid == 0 && mem_req_valid == 0 && buf_we == 0 && fwd_valid == 0,
        "R2", "reset state", {busy, line_valid, mem_req_valid, buf_we, fwd_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_valid = 1'b1;
    rd_idx = 4'd3;
    mem_rsp_valid = 1'b1;
    mem_rsp_data = 32'hDEAD_BEEF;
    #1;
    chk(rd_stall == 1'b1, "R9", "stall before any line", rd_stall, 1);
    chk(buf_we == 1'b0 && fwd_valid == 1'b0, "R11", "idle response ignored",
        {buf_we, fwd_valid}, 0);
    @(negedge clk);
    #1;
    chk(busy == 1'b0 && buf_we == 1'b0, "R11", "idle response no effect",
        {busy, buf_we}, 0);
    for (int m = 1; m >= 0; m--) begin
      for (int c = 0; c < 16; c++) begin
        do_miss(m[0], c, m * 16 + c + 1);
        for (int p = 0; p < 16; p++) begin
          @(negedge clk);
          cyc++;
          rd_valid = 1'b1;
          rd_idx = 4'(p);
          mem_rsp_valid = (p == 7);
          mem_rsp_data = 32'h1234_5678;
          #1;
          chk(rd_stall == 1'b0, "R9", "no stall on whole line", rd_stall, 0);
          if (p == 7) chk(buf_we == 1'b0 && fwd_valid == 1'b0, "R11",
                          "response after completion ignored", {buf_we, fwd_valid}, 0);
        end
        mem_rsp_valid = 1'b0;
      end
    end
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule